// File: doc/BRIEF.md
# Queue Condition Interrupt Controller

This block converts per-queue fill-status flags of a 64-queue hardware queue manager into two interrupt lines. The queues form two halves of 32. Queues 0 to 31 (the lower half) drive `irq_lo`, and queues 32 to 63 (the upper half) drive `irq_hi`. Each lower-half queue has a 3-bit selector. The selector picks one of that queue's four status flags and can invert it. Every upper-half queue always raises its interrupt on its not-nearly-empty flag.

Each half holds a 32-bit enable register and a 32-bit pending register. A pending bit latches when its queue's condition is true and its enable bit is set. Software clears a pending bit by writing a one to it. For each half the block also gives the index of the highest-numbered pending queue, which is the order in which a handler serves that half.

The status flags arrive as plain level inputs. Queue storage lies outside this block. The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready handshake, because every access completes in the cycle it is presented, so there is no back-pressure.

Top module: `qcond_irq_ctrl`

## Requirements
- R1: After reset the selectors, both enable registers and both pending registers read 0, both interrupt lines are low and both valid flags are low.
- R2: The selector of lower queue q sits in register word q/8 (addresses 0 to 3), bits (q mod 8)*4+2 down to (q mod 8)*4. Selector bits 1:0 = k pick input bit `lo_flags[q*4+k]` as the queue's condition.
- R3: When selector bit 2 of a lower queue is set, the chosen flag is inverted before it is used as the condition.
- R4: The condition of upper queue 32+j is always `hi_ne[j]`.
- R5: On each clock edge where a queue's condition is true and its enable bit is set, its pending bit becomes 1. A pending bit is never set while its enable bit is 0. Enable registers are at address 4 (lower) and 5 (upper).
- R6: Writing to a pending register (address 6 lower, 7 upper) clears each bit written as one and leaves the others. Writing 0xFFFFFFFF clears them all. If a bit is set and cleared on the same edge, the set wins.
- R7: Clearing the enable bit and then writing ones to the pending register leaves that pending bit at 0, whatever the condition does.
- R8: Each interrupt line is high exactly when its half's pending register is non-zero, visible in the cycle after the edge that updated it.
- R9: `lo_top_idx`/`hi_top_idx` give the highest-numbered set pending bit of the half. The matching valid flag is 1 exactly when some bit is pending.
- R10: `reg_rdata` shows the register addressed by `reg_addr` in the same cycle. Reserved bit 3 of every selector slot reads 0, whatever was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 selectors, 4/5 enables, 6/7 pending) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of addressed register |
| lo_flags | input | 128 | Four status flags per lower queue, queue q at bits q*4+3:q*4 |
| hi_ne | input | 32 | Not-nearly-empty flag per upper queue |
| irq_lo | output | 1 | Lower-half interrupt |
| irq_hi | output | 1 | Upper-half interrupt |
| lo_top_idx | output | 5 | Highest pending lower queue |
| lo_top_vld | output | 1 | Some lower queue pending |
| hi_top_idx | output | 5 | Highest pending upper queue (offset within half) |
| hi_top_vld | output | 1 | Some upper queue pending |

## Verification
The bench targets the edge where a pending bit is cleared while its condition stays true. A design that let the clear win there would drop an interrupt. It also checks the order of disabling a queue and then clearing it: a design that compared against the new enable too late would re-set the bit. The bench confirms that inversion applies to the flag chosen by that queue's own selector slot, since a wrong slot offset routes another queue's flag. Last, it checks that the index tracks the highest bit, not the lowest, when several bits are pending in one half.

// File: rtl/qci_pkg.sv
package qci_pkg;
  localparam int QPH      = 32;  // queues per half
  localparam int NFLAG    = 4;   // flags per lower queue
  localparam int SEL_W    = 3;   // selector width
  localparam int SLOT_W   = 4;   // selector slot width in a word
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEL0    = 3'd0,
    RA_SEL1    = 3'd1,
    RA_SEL2    = 3'd2,
    RA_SEL3    = 3'd3,
    RA_EN_LO   = 3'd4,
    RA_EN_HI   = 3'd5,
    RA_PEND_LO = 3'd6,
    RA_PEND_HI = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/qci_cond_sel.sv
module qci_cond_sel #(
  parameter int N      = qci_pkg::QPH,
  parameter int NFLAG  = qci_pkg::NFLAG,
  parameter int SEL_W  = qci_pkg::SEL_W,
  parameter int SLOT_W = qci_pkg::SLOT_W,
  parameter int DW     = 32,
  localparam int PER_WORD = DW / SLOT_W,
  localparam int NWORD    = N / PER_WORD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NWORD-1:0]    word_we_i,
  input  logic [PER_WORD*SEL_W-1:0] sel_wd_i,
  input  logic [N*NFLAG-1:0]  flags_i,
  output logic [N-1:0]        cond_o,
  output logic [N*SLOT_W-1:0] sel_rd_o
);
  for (genvar q = 0; q < N; q++) begin : g_q
    localparam int W = q / PER_WORD;
    localparam int S = q % PER_WORD;
    logic [SEL_W-1:0] sel_q;
    logic             flag;

    always_ff @(posedge clk) begin
      if (!rst_n)             sel_q <= '0;
      else if (word_we_i[W])  sel_q <= sel_wd_i[S*SEL_W +: SEL_W];
    end

    assign flag     = flags_i[q*NFLAG + int'(sel_q[1:0])];
    assign cond_o[q] = flag ^ sel_q[2];
    assign sel_rd_o[q*SLOT_W +: SLOT_W] = {{(SLOT_W-SEL_W){1'b0}}, sel_q};
  end
endmodule

// File: rtl/qci_pend_bank.sv
module qci_pend_bank #(
  parameter int N  = qci_pkg::QPH,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cond_i,
  input  logic          en_we_i,
  input  logic          clr_we_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  pend_o,
  output logic          irq_o,
  output logic [IW-1:0] top_idx_o,
  output logic          top_vld_o
);
  logic [N-1:0] en_q, pend_q, clr, set;

  assign clr = clr_we_i ? wdata_i : '0;
  assign set = cond_i & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | set;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  always_comb begin
    top_idx_o = '0;
    top_vld_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_q[i]) begin
        top_idx_o = IW'(i);
        top_vld_o = 1'b1;
      end
    end
  end

  assign irq_o  = |pend_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(pend_q) & ~$past(clr))) & ~pend_q) == '0));
  // R5
  set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q & ~$past(pend_q)) & ~($past(cond_i) & $past(en_q))) == '0));
  // R9
  top_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld_o ? ((pend_q >> top_idx_o) == N'(1)) : (pend_q == '0));
endmodule

// File: rtl/qcond_irq_ctrl.sv
module qcond_irq_ctrl
  import qci_pkg::*;
#(
  parameter int DW = QPH,
  localparam int IW       = $clog2(QPH),
  localparam int PER_WORD = DW / SLOT_W,
  localparam int NWORD    = QPH / PER_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [QPH*NFLAG-1:0] lo_flags,
  input  logic [QPH-1:0]    hi_ne,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic [IW-1:0]     lo_top_idx,
  output logic              lo_top_vld,
  output logic [IW-1:0]     hi_top_idx,
  output logic              hi_top_vld
);
  logic [NWORD-1:0]          sel_we;
  logic [PER_WORD*SEL_W-1:0] sel_wd;
  logic [QPH*SLOT_W-1:0]     sel_rd;
  logic [QPH-1:0]            lo_cond;
  logic [QPH-1:0]            en_lo, en_hi, pend_lo, pend_hi;

  for (genvar w = 0; w < NWORD; w++) begin : g_we
    assign sel_we[w] = reg_we && (int'(reg_addr) == w);
  end
  for (genvar s = 0; s < PER_WORD; s++) begin : g_wd
    assign sel_wd[s*SEL_W +: SEL_W] = reg_wdata[s*SLOT_W +: SEL_W];
  end

  qci_cond_sel #(.N(QPH), .DW(DW)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_we_i(sel_we),
    .sel_wd_i (sel_wd),
    .flags_i  (lo_flags),
    .cond_o   (lo_cond),
    .sel_rd_o (sel_rd)
  );

  qci_pend_bank #(.N(QPH)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (lo_cond),
    .en_we_i  (reg_we && reg_addr == RA_EN_LO),
    .clr_we_i (reg_we && reg_addr == RA_PEND_LO),
    .wdata_i  (reg_wdata),
    .en_o     (en_lo),
    .pend_o   (pend_lo),
    .irq_o    (irq_lo),
    .top_idx_o(lo_top_idx),
    .top_vld_o(lo_top_vld)
  );

  qci_pend_bank #(.N(QPH)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (hi_ne),
    .en_we_i  (reg_we && reg_addr == RA_EN_HI),
    .clr_we_i (reg_we && reg_addr == RA_PEND_HI),
    .wdata_i  (reg_wdata),
    .en_o     (en_hi),
    .pend_o   (pend_hi),
    .irq_o    (irq_hi),
    .top_idx_o(hi_top_idx),
    .top_vld_o(hi_top_vld)
  );

  always_comb begin
    case (reg_addr)
      RA_EN_LO:   reg_rdata = en_lo;
      RA_EN_HI:   reg_rdata = en_hi;
      RA_PEND_LO: reg_rdata = pend_lo;
      RA_PEND_HI: reg_rdata = pend_hi;
      default:    reg_rdata = sel_rd[int'(reg_addr[1:0])*DW +: DW];
    endcase
  end

  // R7
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_PEND_LO && reg_wdata == '1 && en_lo == '0)
      |=> (pend_lo == '0));
  // R8
  irq_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo == lo_top_vld) && (irq_hi == hi_top_vld));
endmodule

// File: tb/qcond_irq_ctrl_bench.sv
module qcond_irq_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [127:0] lo_flags = 0;
  logic [31:0] hi_ne = 0;
  logic        irq_lo, irq_hi, lo_top_vld, hi_top_vld;
  logic [4:0]  lo_top_idx, hi_top_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qcond_irq_ctrl u_qcond_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_flags(lo_flags),
    .hi_ne(hi_ne), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .lo_top_idx(lo_top_idx), .lo_top_vld(lo_top_vld),
    .hi_top_idx(hi_top_idx), .hi_top_vld(hi_top_vld)
  );

  // behavioural model
  logic [31:0] m_sel [4];
  logic [31:0] m_en  [2];
  logic [31:0] m_pend[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_sel[i] = 0;
      for (int h = 0; h < 2; h++) begin m_en[h] = 0; m_pend[h] = 0; end
    end else begin
      logic [31:0] set_lo, set_hi, clr_lo, clr_hi;
      set_lo = 0;
      for (int q = 0; q < 32; q++) begin
        int s;
        bit c;
        s = (m_sel[q/8] >> ((q%8)*4)) & 7;
        c = lo_flags[q*4 + (s & 3)] ^ ((s & 4) != 0);
        if (c && m_en[0][q]) set_lo[q] = 1'b1;
      end
      set_hi = hi_ne & m_en[1];
      clr_lo = (reg_we && reg_addr == 6) ? reg_wdata : 0;
      clr_hi = (reg_we && reg_addr == 7) ? reg_wdata : 0;
      m_pend[0] = (m_pend[0] & ~clr_lo) | set_lo;
      m_pend[1] = (m_pend[1] & ~clr_hi) | set_hi;
      if (reg_we) begin
        if (reg_addr < 4) m_sel[reg_addr] = reg_wdata & 32'h7777_7777;
        else if (reg_addr == 4) m_en[0] = reg_wdata;
        else if (reg_addr == 5) m_en[1] = reg_wdata;
      end
    end
  end

  function automatic logic [31:0] m_rd(input int a);
    if (a < 4) return m_sel[a];
    if (a == 4) return m_en[0];
    if (a == 5) return m_en[1];
    if (a == 6) return m_pend[0];
    return m_pend[1];
  endfunction

  function automatic logic [5:0] m_top(input logic [31:0] p);
    for (int i = 31; i >= 0; i--) if (p[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8 irq_lo", 32'(irq_lo), 32'(m_pend[0] != 0));
      chk("R8 irq_hi", 32'(irq_hi), 32'(m_pend[1] != 0));
      chk("R9 lo top", {26'd0, lo_top_vld, lo_top_idx}, 32'(m_top(m_pend[0])));
      chk("R9 hi top", {26'd0, hi_top_vld, hi_top_idx}, 32'(m_top(m_pend[1])));
      chk("R10 rdata", reg_rdata, m_rd(int'(reg_addr)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_we = 0; reg_addr = a;
    @(posedge clk);
    #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd_chk(4, 0, "R1 en_lo");
    rd_chk(6, 0, "R1 pend_lo");
    rd_chk(0, 0, "R1 sel0");
    chk("R1 irq", {irq_hi, irq_lo, hi_top_vld, lo_top_vld}, 0);
    // R2: queue 5 uses flag 2
    lo_flags[5*4+2] = 1'b1;
    wr(0, 32'd2 << 20);
    rd_chk(6, 0, "R5 no set while disabled");
    wr(4, 32'd1 << 5);
    rd_chk(6, 32'd1 << 5, "R2 flag select");
    chk("R9 idx 5", {26'd0, lo_top_vld, lo_top_idx}, {26'd0, 1'b1, 5'd5});
    chk("R8 irq_lo high", 32'(irq_lo), 1);
    // R3: queue 9 inverted flag 1 (flag is 0 -> condition true)
    wr(1, 32'd5 << 4);
    wr(4, (32'd1 << 5) | (32'd1 << 9));
    rd_chk(6, (32'd1 << 5) | (32'd1 << 9), "R3 invert");
    chk("R9 highest idx", {26'd0, lo_top_vld, lo_top_idx}, {26'd0, 1'b1, 5'd9});
    // R6: set wins over clear while condition holds
    wr(6, 32'd1 << 9);
    rd_chk(6, (32'd1 << 5) | (32'd1 << 9), "R6 set wins");
    lo_flags[9*4+1] = 1'b1;
    wr(6, 32'd1 << 9);
    rd_chk(6, 32'd1 << 5, "R6 w1c");
    // R7: disable then clear all
    wr(4, 0);
    wr(6, 32'hFFFF_FFFF);
    rd_chk(6, 0, "R7 disable then clear");
    chk("R8 irq_lo low", 32'(irq_lo), 0);
    // R4: upper half on not-nearly-empty
    hi_ne = 32'd1 << 3;
    wr(5, (32'd1 << 3) | (32'd1 << 20));
    rd_chk(7, 32'd1 << 3, "R4 hi cond");
    hi_ne = hi_ne | (32'd1 << 20);
    rd_chk(7, (32'd1 << 3) | (32'd1 << 20), "R4 hi second");
    chk("R9 hi idx 20", {26'd0, hi_top_vld, hi_top_idx}, {26'd0, 1'b1, 5'd20});
    hi_ne = 0;
    wr(7, 32'hFFFF_FFFF);
    rd_chk(7, 0, "R6 clear all hi");
    // R10: reserved bits read zero
    wr(2, 32'hFFFF_FFFF);
    rd_chk(2, 32'h7777_7777, "R10 reserved");
    // mixed traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lo_flags  = {$urandom, $urandom, $urandom, $urandom};
      hi_ne     = $urandom & $urandom;
      reg_we    = ($urandom % 4) == 0;
      reg_addr  = 3'($urandom);
      reg_wdata = $urandom;
    end
    @(negedge clk) reg_we = 0;
    repeat (2) @(posedge clk);
    #2;
    finish_run();
  end
endmodule